// File: doc/BRIEF.md
# Thermal Shutdown Latch with Event Counting

This block decides whether the power stages of a supply chip may run, based on two comparator flags from a temperature sensor. These flags are already synchronized to the block's clock. One flag reports that the die is above the trip temperature. The other reports that it has cooled below the lower recovery temperature.

A trip shuts the power stages down and raises a status flag. Normal operation returns only once the recovery flag is seen, which gives hysteresis between the two thresholds. The block counts each trip. On a set number of trips (four by default) it stops recovering and latches off. It then holds the status flag high and pulls an active-low fault pin low.

The latch, and the trip count with it, can be cleared in two ways: a power-on reset, or an enable control bit taken low and then high again. While the enable bit is low, the power stages are held off regardless of temperature. All pins are plain level control and status signals; there is no streaming data path, so no handshake is involved.

Top module: `ots_thermal_guard`

## Requirements
- R1: After reset release with no trip, `temp_flag_o` is 0, `fault_n_o` is 1 and `power_off_o` equals the inverse of `enable_i`.
- R2: A rising edge of `trip_hot_i` (high now, low at the previous clock edge) in the running state sets `temp_flag_o` and `power_off_o` to 1 after that clock edge.
- R3: Once tripped and not latched, `temp_flag_o` and `power_off_o` stay 1 until a clock edge samples `recov_cool_i` high, including while `trip_hot_i` has fallen but recovery is not yet reported; after that edge `temp_flag_o` is 0.
- R4: A trip is counted once per rising edge of `trip_hot_i`, whether running or already tripped; holding the flag high for many cycles counts one trip.
- R5: The rising edge that makes the count reach LATCH_COUNT (default 4) enters the latched state, which neither `recov_cool_i` nor further trips leave.
- R6: While `enable_i` is low, `power_off_o` is 1 in the same cycle, whatever the thermal state.
- R7: A clock edge that samples `enable_i` high, after the previous edge sampled it low, returns the block to running with a zero count; this takes priority over a trip edge sampled at the same clock edge, which is then not counted.
- R8: Power-on reset (`rst_n` low) clears the latch and the count.
- R9: `fault_n_o` is 0 exactly in the latched state, and whenever it is 0, both `temp_flag_o` and `power_off_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| trip_hot_i | input | 1 | Synchronized flag: die above trip temperature |
| recov_cool_i | input | 1 | Synchronized flag: die below recovery temperature |
| enable_i | input | 1 | Enable control bit; a low-then-high sequence clears the latch |
| power_off_o | output | 1 | 1 shuts down the power stages |
| temp_flag_o | output | 1 | Over-temperature status bit |
| fault_n_o | output | 1 | Active-low fault output, low when latched off |

## Verification
The bench builds the block with its default parameters: a 3-bit counter and a latch on the fourth trip. With these values, the full path to the latch fits in a short run. The path mixes held trips, trips that re-arm inside the hysteresis band, and single-cycle pulses, so that a miscount by one shows up as a latch that comes early or late. A behavioural model runs alongside and predicts all three outputs on every clock. Two cases in particular are compared against it: an enable rising edge that coincides with a trip edge, and a reset applied while latched.

// File: rtl/ots_pkg.sv
package ots_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_TRIP  = 2'd1,
    ST_LATCH = 2'd2
  } ots_state_e;
endpackage

// File: rtl/ots_edge.sv
module ots_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/ots_event_counter.sv
module ots_event_counter #(
  parameter int CNT_W       = 3,
  parameter int LATCH_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam logic [CNT_W-1:0] LIM    = CNT_W'(LATCH_COUNT);
  localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(LATCH_COUNT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LIM_M1);

  // R5: the count saturates at the latch value
  p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LIM && !clr_i) |=> (cnt_q == LIM));
  // R7: the enable sequence zeroes the count
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/ots_thermal_fsm.sv
module ots_thermal_fsm
  import ots_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       hot_rise_i,
  input  logic       cool_i,
  input  logic       last_i,
  output ots_state_e state_o
);
  ots_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clr_i) begin
      st_d = ST_RUN;
    end else begin
      case (st_q)
        ST_RUN, ST_TRIP: begin
          if (hot_rise_i)      st_d = last_i ? ST_LATCH : ST_TRIP;
          else if (st_q == ST_TRIP && cool_i) st_d = ST_RUN;
        end
        default: st_d = ST_LATCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R2: a trip edge while running shuts down
  p_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && hot_rise_i && !clr_i) |=> (st_q != ST_RUN));
  // R3: tripped state holds until recovery is reported
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRIP && !cool_i && !clr_i) |=> (st_q != ST_RUN));
  // R5: latched state is left only through the clear
  p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LATCH && !clr_i) |=> (st_q == ST_LATCH));
endmodule

// File: rtl/ots_thermal_guard.sv
module ots_thermal_guard
  import ots_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int LATCH_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_hot_i,
  input  logic recov_cool_i,
  input  logic enable_i,
  output logic power_off_o,
  output logic temp_flag_o,
  output logic fault_n_o
);
  logic [1:0] rise;
  logic       hot_rise, en_rise, last, inc;
  ots_state_e state;

  ots_edge #(.W(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i ({enable_i, trip_hot_i}),
    .rise_o(rise)
  );
  assign hot_rise = rise[0];
  assign en_rise  = rise[1];

  assign inc = hot_rise & ~en_rise & (state != ST_LATCH);

  ots_event_counter #(.CNT_W(CNT_W), .LATCH_COUNT(LATCH_COUNT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (en_rise),
    .inc_i (inc),
    .last_o(last)
  );

  ots_thermal_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (en_rise),
    .hot_rise_i(hot_rise),
    .cool_i    (recov_cool_i),
    .last_i    (last),
    .state_o   (state)
  );

  assign temp_flag_o = (state != ST_RUN);
  assign fault_n_o   = (state != ST_LATCH);
  assign power_off_o = temp_flag_o | ~enable_i;

  // R6: disabled means powered off
  p_en_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> power_off_o);
  // R9: fault implies flag and shutdown
  p_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> (temp_flag_o && power_off_o));
  // R7: enable rising edge returns to running
  p_en_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !$past(enable_i) && $past(rst_n)) |=> (fault_n_o && !temp_flag_o));
endmodule

// File: tb/test_ots_thermal_guard.sv
module test_ots_thermal_guard;
  localparam int LIMIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hot = 1'b0, cool = 1'b0, en = 1'b0;
  logic pwr_off, otf, fault_n;

  int total = 0;
  int bad = 0;
  int m_st = 0;
  int m_cnt = 0;
  bit m_ph = 0, m_pe = 0;

  always #4 clk = ~clk;

  ots_thermal_guard i_ots_thermal_guard (
    .clk(clk), .rst_n(rst_n), .trip_hot_i(hot), .recov_cool_i(cool),
    .enable_i(en), .power_off_o(pwr_off), .temp_flag_o(otf), .fault_n_o(fault_n)
  );

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_ph = 0; m_pe = 0;
  endtask

  task automatic model_clock();
    bit hr, er;
    hr = hot && !m_ph;
    er = en && !m_pe;
    if (er) begin
      m_st = 0; m_cnt = 0;
    end else if (m_st != 2) begin
      if (hr) begin
        m_cnt++;
        m_st = (m_cnt >= LIMIT) ? 2 : 1;
      end else if (m_st == 1 && cool) begin
        m_st = 0;
      end
    end
    m_ph = hot; m_pe = en;
  endtask

  task automatic compare(string tag);
    bit e_otf, e_fn, e_off;
    e_otf = (m_st != 0);
    e_fn  = (m_st != 2);
    e_off = e_otf || !en;
    total++;
    if (otf !== e_otf || fault_n !== e_fn || pwr_off !== e_off) begin
      bad++;
      $display("FAIL %s: otf/fault_n/pwr_off got %b%b%b expected %b%b%b",
               tag, otf, fault_n, pwr_off, e_otf, e_fn, e_off);
    end
  endtask

  // drive at negedge, clock, compare 2 ns after the edge
  task automatic step(bit h, bit c, bit e, string tag);
    hot = h; cool = c; en = e;
    @(posedge clk);
    if (rst_n) model_clock(); else model_reset();
    #2;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    step(0, 0, 0, "R8 reset");
    step(0, 0, 0, "R8 reset");
    rst_n = 1'b1;
    step(0, 0, 0, "R1 idle disabled");
    step(0, 0, 1, "R1 enable");
    step(0, 0, 1, "R1 running");
    // trip 1: single pulse, then recovery
    step(1, 0, 1, "R2 trip edge");
    step(0, 0, 1, "R3 band hold");
    step(0, 0, 1, "R3 band hold");
    step(0, 1, 1, "R3 recover");
    step(0, 0, 1, "R3 running");
    // trip 2: held high many cycles, counted once
    for (int i = 0; i < 6; i++) step(1, 0, 1, "R4 held trip");
    step(0, 0, 1, "R3 band");
    // trip 3: re-trip inside the band while tripped
    step(1, 0, 1, "R4 retrip in band");
    step(0, 1, 1, "R3 recover");
    step(0, 0, 1, "R3 running");
    // trip 4: latch
    step(1, 0, 1, "R5 fourth trip latches");
    step(0, 1, 1, "R5 cool ignored");
    step(1, 1, 1, "R9 latched");
    step(0, 1, 1, "R5 still latched");
    // enable low then high clears
    step(0, 1, 0, "R6 disabled");
    step(0, 0, 0, "R6 disabled");
    step(0, 0, 1, "R7 clear");
    step(0, 0, 1, "R7 running");
    // enable rising edge coincides with trip edge
    step(0, 0, 0, "R6 off");
    step(1, 0, 1, "R7 priority");
    step(1, 0, 1, "R7 no count");
    step(0, 1, 1, "R7 recover");
    // four fresh trips needed after clear
    for (int k = 0; k < LIMIT; k++) begin
      step(1, 0, 1, "R5 count after clear");
      step(0, 1, 1, "R5 count after clear");
    end
    step(0, 0, 1, "R5 latched");
    step(0, 0, 0, "R6 disabled while latched");
    // power-on reset clears latch
    rst_n = 1'b0;
    step(0, 0, 1, "R8 reset in latch");
    rst_n = 1'b1;
    step(0, 0, 1, "R8 after reset");
    step(1, 0, 1, "R2 trip after reset");
    step(0, 1, 1, "R3 recover after reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule